// File: doc/BRIEF.md
# Chainable Four-Channel PWM Bank

This block holds a set of independent pulse-width modulators that run from one 24 MHz master clock. Each channel counts ticks of a clock source it selects, has an 8-bit period and an 8-bit pulse width, and drives a high level for the first part of each period. Four sources come from a shared prescaler: the master rate, 1.5 MHz, 93.75 kHz and an approximate 32 kHz. A fifth, slower source comes from the 93.75 kHz rate through a divider that software sets between 1 and 255, so 255 gives about 367.6 Hz. The sixth choice clocks a channel from the rising edges of the channel below it. Chaining channels this way gives very long periods.

All fixed sources are single-cycle enables in the master clock domain, so nothing runs on a derived clock. A new period or pulse width takes effect only when the running period ends, so no pulse is ever cut short. A per-pin select chooses between a channel's waveform and an ordinary output latch bit for each pin.

Top module: `pwm_bank`

## Requirements
- R1: While reset is asserted, and right after it is released, every PWM output is low and each channel's active period is 1 and its active width is 0.
- R2: The 3-bit source code of a channel selects its clock: 0 = 32 kHz, 1 = master (24 MHz), 2 = 1.5 MHz, 3 = 93.75 kHz, 4 = slow divided source, 5 = rising edge of the previous channel. Codes 6 and 7 act as code 0. An all-zero configuration therefore runs every channel from 32 kHz.
- R3: The master source ticks every cycle. The 1.5 MHz source ticks once every MID_DIV cycles. The 93.75 kHz source ticks once every MID_DIV*LOW_DIV cycles. The 32 kHz source ticks once every K32_DIV cycles. All counting starts at reset release.
- R4: The slow source ticks on every slow_div-th tick of the 93.75 kHz source. A slow_div of 0 acts as 1.
- R5: A channel's output period equals its active period value times the interval between ticks of its source. A period value of 0 acts as 1.
- R6: The output is high while the channel's tick count within the period is below the active width, and low otherwise. An active width of 0 gives a constant low.
- R7: A width at or above the period is limited to period minus one, so the output always spends at least one tick of each period low.
- R8: Changes to a channel's period or width inputs are taken into the active values only at the tick that ends the current period.
- R9: With code 5, a channel advances once per rising edge of the previous channel's output. Channel 0 has no predecessor and treats code 5 as code 0.
- R10: Each pin shows its channel's PWM output when its select bit is 1, and the output latch bit when the select bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_div | input | SDW | Divider for the slow source (0 acts as 1) |
| src_sel | input | 3*NCH | Source code per channel, channel i in bits [3i+2:3i] |
| period | input | CW*NCH | Period value per channel, channel i in bits [CW*i+CW-1:CW*i] |
| width | input | CW*NCH | Pulse width per channel, same packing as period |
| pin_sel | input | NCH | Per-pin choice: 1 = PWM, 0 = output latch |
| out_latch | input | NCH | Ordinary output level per pin |
| pwm_out | output | NCH | Raw waveform of each channel |
| pin_out | output | NCH | Level driven on each pin |

## Verification
The bench builds the bank with four channels of 8 bits, MID_DIV = 4, LOW_DIV = 2 and K32_DIV = 6 in place of the real divisions of 16, 16 and 750. With these values one 93.75 kHz tick takes 8 cycles, and slow-source periods, two-level chains and the 32 kHz fallback of channel 0 each fit into a few hundred cycles. A behavioural model follows every channel on every clock. Directed measurements of rising-edge spacing and high-time cover each source, the width limit and the deferred loading.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // Clock source codes of a channel
  typedef enum logic [2:0] {
    SRC_32K  = 3'd0,
    SRC_24M  = 3'd1,
    SRC_1M5  = 3'd2,
    SRC_94K  = 3'd3,
    SRC_SLOW = 3'd4,
    SRC_PREV = 3'd5
  } src_e;

  // Single-cycle enables shared by all channels
  typedef struct packed {
    logic f24m;
    logic f1m5;
    logic f94k;
    logic f32k;
    logic slow;
  } tick_bus_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_bank_pkg::*;
#(
  parameter int MID_DIV = 16,
  parameter int LOW_DIV = 16,
  parameter int K32_DIV = 750,
  parameter int SDW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SDW-1:0] slow_div,
  output tick_bus_t      ticks
);

  localparam int MW = $clog2(MID_DIV + 1);
  localparam int LW = $clog2(LOW_DIV + 1);
  localparam int KW = $clog2(K32_DIV + 1);
  localparam logic [MW-1:0] MID_LAST = MW'(MID_DIV - 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(LOW_DIV - 1);
  localparam logic [KW-1:0] K32_LAST = KW'(K32_DIV - 1);

  // 0 on the divider input behaves like 1
  function automatic logic [SDW-1:0] div_last(input logic [SDW-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  logic [MW-1:0]  c_mid;
  logic [LW-1:0]  c_low;
  logic [KW-1:0]  c_k32;
  logic [SDW-1:0] c_slow;
  logic           mid_hit, low_hit, k32_hit, slow_hit;

  assign mid_hit  = (c_mid == MID_LAST);
  assign low_hit  = mid_hit && (c_low == LOW_LAST);
  assign k32_hit  = (c_k32 == K32_LAST);
  assign slow_hit = low_hit && (c_slow >= div_last(slow_div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mid  <= '0;
      c_low  <= '0;
      c_k32  <= '0;
      c_slow <= '0;
    end else begin
      c_mid <= mid_hit ? '0 : c_mid + 1'b1;
      c_k32 <= k32_hit ? '0 : c_k32 + 1'b1;
      if (mid_hit) c_low <= (c_low == LOW_LAST) ? '0 : c_low + 1'b1;
      if (low_hit) c_slow <= slow_hit ? '0 : c_slow + 1'b1;
    end
  end

  always_comb begin
    ticks.f24m = 1'b1;
    ticks.f1m5 = mid_hit;
    ticks.f94k = low_hit;
    ticks.f32k = k32_hit;
    ticks.slow = slow_hit;
  end

endmodule

// File: rtl/pwm_src_mux.sv
module pwm_src_mux
  import pwm_bank_pkg::*;
#(
  parameter bit CHAIN_OK = 1'b1
) (
  input  logic [2:0] sel,
  input  tick_bus_t  ticks,
  input  logic       prev_rise,
  output logic       tick
);

  always_comb begin
    case (sel)
      SRC_24M:  tick = ticks.f24m;
      SRC_1M5:  tick = ticks.f1m5;
      SRC_94K:  tick = ticks.f94k;
      SRC_SLOW: tick = ticks.slow;
      SRC_PREV: tick = CHAIN_OK ? prev_rise : ticks.f32k;
      default:  tick = ticks.f32k;
    endcase
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] width_in,
  output logic          pwm,
  output logic          wrap,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] wid_o
);

  function automatic logic [CW-1:0] fix_period(input logic [CW-1:0] p);
    return (p == '0) ? CW'(1) : p;
  endfunction

  function automatic logic [CW-1:0] fix_width(input logic [CW-1:0] w,
                                              input logic [CW-1:0] p);
    return (w >= p) ? p - 1'b1 : w;
  endfunction

  logic [CW-1:0] cnt, act_p, act_w, next_p;

  assign next_p = fix_period(period_in);
  assign wrap   = tick && (cnt >= act_p - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      act_p <= CW'(1);
      act_w <= '0;
    end else if (wrap) begin
      cnt   <= '0;
      act_p <= next_p;
      act_w <= fix_width(width_in, next_p);
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign pwm   = (cnt < act_w);
  assign cnt_o = cnt;
  assign per_o = act_p;
  assign wid_o = act_w;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CW      = 8,
  parameter int SDW     = 8,
  parameter int MID_DIV = 16,
  parameter int LOW_DIV = 16,
  parameter int K32_DIV = 750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SDW-1:0]    slow_div,
  input  logic [3*NCH-1:0]  src_sel,
  input  logic [CW*NCH-1:0] period,
  input  logic [CW*NCH-1:0] width,
  input  logic [NCH-1:0]    pin_sel,
  input  logic [NCH-1:0]    out_latch,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pin_out
);

  tick_bus_t         ticks;
  logic              en_mid, en_32k;
  logic [NCH-1:0]    ch_tick, ch_wrap, prev_rise;
  logic [CW*NCH-1:0] ch_cnt, ch_per, ch_wid;

  pwm_prescaler #(
    .MID_DIV(MID_DIV), .LOW_DIV(LOW_DIV), .K32_DIV(K32_DIV), .SDW(SDW)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_div(slow_div), .ticks(ticks)
  );

  assign en_mid = ticks.f1m5;
  assign en_32k = ticks.f32k;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_head
      assign prev_rise[i] = 1'b0;
    end else begin : g_link
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pwm_out[i-1];
      end
      assign prev_rise[i] = pwm_out[i-1] & ~prev_q;
    end

    pwm_src_mux #(.CHAIN_OK(i != 0)) u_mux (
      .sel(src_sel[3*i +: 3]), .ticks(ticks),
      .prev_rise(prev_rise[i]), .tick(ch_tick[i])
    );

    pwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(ch_tick[i]),
      .period_in(period[CW*i +: CW]), .width_in(width[CW*i +: CW]),
      .pwm(pwm_out[i]), .wrap(ch_wrap[i]),
      .cnt_o(ch_cnt[CW*i +: CW]), .per_o(ch_per[CW*i +: CW]),
      .wid_o(ch_wid[CW*i +: CW])
    );

    assign pin_out[i] = pin_sel[i] ? pwm_out[i] : out_latch[i];
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH     = 4,
  parameter int CW      = 8,
  parameter int MID_DIV = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3*NCH-1:0]  src_sel,
  input logic [NCH-1:0]    pin_sel,
  input logic [NCH-1:0]    out_latch,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    pin_out,
  input logic              en_mid,
  input logic              en_32k,
  input logic [NCH-1:0]    ch_tick,
  input logic [NCH-1:0]    ch_wrap,
  input logic [CW*NCH-1:0] ch_cnt,
  input logic [CW*NCH-1:0] ch_per,
  input logic [CW*NCH-1:0] ch_wid
);

  if (MID_DIV > 1) begin : g_mid
    AST_MID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      en_mid |=> !en_mid); // R3
  end

  AST_HEAD_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel[2:0] == 3'd5) |-> (ch_tick[0] == en_32k)); // R9

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_FAST_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel[3*i +: 3] == 3'd1) |-> ch_tick[i]); // R3
    AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cnt[CW*i +: CW] < ch_per[CW*i +: CW]); // R5
    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wrap[i] |=> (ch_cnt[CW*i +: CW] == '0)); // R5
    AST_WIDTH_LIMITED: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wid[CW*i +: CW] < ch_per[CW*i +: CW]); // R7
    AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wid[CW*i +: CW] == '0) |-> !pwm_out[i]); // R6
    AST_LOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_wrap[i] |=> ($stable(ch_per[CW*i +: CW]) && $stable(ch_wid[CW*i +: CW]))); // R8
    AST_LATCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_sel[i] |-> (pin_out[i] == out_latch[i])); // R10
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW), .MID_DIV(MID_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pin_sel(pin_sel),
  .out_latch(out_latch), .pwm_out(pwm_out), .pin_out(pin_out),
  .en_mid(en_mid), .en_32k(en_32k), .ch_tick(ch_tick), .ch_wrap(ch_wrap),
  .ch_cnt(ch_cnt), .ch_per(ch_per), .ch_wid(ch_wid)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

  localparam int TCLK = 10;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int SDW  = 8;
  localparam int MID  = 4;
  localparam int LOW  = 2;
  localparam int K32  = 6;
  localparam int WDOG = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [SDW-1:0]    slow_div = '0;
  logic [3*NCH-1:0]  src_sel;
  logic [CW*NCH-1:0] period, width;
  logic [NCH-1:0]    pin_sel = '1;
  logic [NCH-1:0]    out_latch = '0;
  logic [NCH-1:0]    pwm_out, pin_out;

  int b_src [NCH];
  int b_per [NCH];
  int b_wid [NCH];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(TCLK/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      src_sel[3*i +: 3] = 3'(b_src[i]);
      period[CW*i +: CW] = CW'(b_per[i]);
      width[CW*i +: CW]  = CW'(b_wid[i]);
    end
  end

  pwm_bank #(
    .NCH(NCH), .CW(CW), .SDW(SDW), .MID_DIV(MID), .LOW_DIV(LOW), .K32_DIV(K32)
  ) i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .slow_div(slow_div), .src_sel(src_sel),
    .period(period), .width(width), .pin_sel(pin_sel), .out_latch(out_latch),
    .pwm_out(pwm_out), .pin_out(pin_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_cnt [NCH];
  int m_per [NCH];
  int m_wid [NCH];
  int m_prv [NCH];
  int m_n, m_sc;

  function automatic int p_eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int w_eff(input int w, input int p);
    return (w > p - 1) ? p - 1 : w;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_sc = 0;
      foreach (m_cnt[i]) begin
        m_cnt[i] = 0; m_per[i] = 1; m_wid[i] = 0; m_prv[i] = 0;
      end
    end else begin
      bit o [NCH];
      bit t [NCH];
      bit mid, low, k32, slw;
      int exp_pwm, exp_pin, d;
      exp_pwm = 0; exp_pin = 0;
      foreach (o[i]) begin
        o[i] = (m_cnt[i] < m_wid[i]);
        exp_pwm |= int'(o[i]) << i;
        exp_pin |= int'(pin_sel[i] ? o[i] : out_latch[i]) << i;
      end
      check(pwm_out == NCH'(exp_pwm), "R5/R6/R8", "pwm_out vs model",
            int'(pwm_out), exp_pwm);
      check(pin_out == NCH'(exp_pin), "R10", "pin_out vs model",
            int'(pin_out), exp_pin);
      mid = (m_n % MID) == MID - 1;
      low = (m_n % (MID * LOW)) == MID * LOW - 1;
      k32 = (m_n % K32) == K32 - 1;
      d = (slow_div == 0) ? 1 : int'(slow_div);
      slw = 1'b0;
      if (low) begin
        if (m_sc >= d - 1) begin slw = 1'b1; m_sc = 0; end
        else m_sc++;
      end
      foreach (t[i]) begin
        case (b_src[i])
          1: t[i] = 1'b1;
          2: t[i] = mid;
          3: t[i] = low;
          4: t[i] = slw;
          5: t[i] = (i == 0) ? k32 : (o[i-1] && m_prv[i] == 0);
          default: t[i] = k32;
        endcase
      end
      foreach (t[i]) begin
        if (i > 0) m_prv[i] = int'(o[i-1]);
        if (t[i]) begin
          if (m_cnt[i] + 1 >= m_per[i]) begin
            m_cnt[i] = 0;
            m_per[i] = p_eff(b_per[i]);
            m_wid[i] = w_eff(b_wid[i], m_per[i]);
          end else m_cnt[i]++;
        end
      end
      m_n++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg(input int ch, input int src, input int per, input int wid);
    @(posedge clk); #1;
    b_src[ch] = src; b_per[ch] = per; b_wid[ch] = wid;
  endtask

  task automatic wait_rise(input int ch);
    bit last;
    @(negedge clk); last = pwm_out[ch];
    forever begin
      @(negedge clk);
      if (pwm_out[ch] && !last) break;
      last = pwm_out[ch];
    end
  endtask

  task automatic measure(input int ch, output int cyc);
    bit last;
    wait_rise(ch);
    wait_rise(ch);
    cyc = 0; last = 1'b1;
    forever begin
      @(negedge clk); cyc++;
      if (pwm_out[ch] && !last) break;
      last = pwm_out[ch];
    end
  endtask

  task automatic highs(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_out[ch]);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int c, h;
    foreach (b_src[i]) begin b_src[i] = 0; b_per[i] = 0; b_wid[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(pwm_out == '0, "R1", "pwm_out in reset", int'(pwm_out), 0);
    check(pin_out == '0, "R1", "pin_out in reset", int'(pin_out), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == '0, "R1", "pwm_out after release", int'(pwm_out), 0);

    // R2/R3: code 0 default, 32 kHz tick every K32 cycles
    cfg(0, 0, 2, 1);
    measure(0, c); check(c == 2 * K32, "R2", "code0 spacing", c, 2 * K32);
    // R2: unused code 7 behaves as code 0
    cfg(0, 7, 3, 1);
    measure(0, c); check(c == 3 * K32, "R2", "code7 spacing", c, 3 * K32);
    // R3: master rate
    cfg(1, 1, 5, 2);
    measure(1, c); check(c == 5, "R3", "24M spacing", c, 5);
    // R3: 1.5 MHz
    cfg(2, 2, 3, 1);
    measure(2, c); check(c == 3 * MID, "R3", "1M5 spacing", c, 3 * MID);
    // R3: 93.75 kHz
    cfg(3, 3, 2, 1);
    measure(3, c); check(c == 2 * MID * LOW, "R3", "94k spacing", c, 2 * MID * LOW);
    // R4: slow source with divider 3 and 0
    @(posedge clk); #1; slow_div = 8'd3;
    cfg(3, 4, 2, 1);
    measure(3, c); check(c == 2 * 3 * MID * LOW, "R4", "slow div3", c, 2 * 3 * MID * LOW);
    @(posedge clk); #1; slow_div = 8'd0;
    measure(3, c); check(c == 2 * MID * LOW, "R4", "slow div0", c, 2 * MID * LOW);
    // R5: period 0 acts as 1 -> width limited to 0, constant low
    cfg(1, 1, 0, 3);
    wait_rise(2); highs(1, 40, h); check(h == 0, "R5", "period0 highs", h, 0);
    // R5/R6: duty 3 of 10 at master rate
    cfg(1, 1, 10, 3);
    wait_rise(1); highs(1, 100, h); check(h == 30, "R6", "duty 3/10", h, 30);
    // R6: width 0 constant low
    cfg(1, 1, 10, 0);
    repeat (30) @(negedge clk); highs(1, 50, h); check(h == 0, "R6", "width0 highs", h, 0);
    // R7: width above period limited to period-1
    cfg(1, 1, 4, 9);
    repeat (10) @(negedge clk); highs(1, 40, h); check(h == 30, "R7", "width clamp", h, 30);
    // R8: period change waits for the end of the running period
    cfg(1, 1, 200, 100);
    wait_rise(1); wait_rise(1);
    @(posedge clk); #1; b_per[1] = 5; b_wid[1] = 2;
    c = 0;
    begin
      bit last; last = 1'b1;
      forever begin
        @(negedge clk); c++;
        if (pwm_out[1] && !last) break;
        last = pwm_out[1];
      end
    end
    check(c == 200, "R8", "deferred period", c, 200);
    measure(1, c); check(c == 5, "R8", "new period", c, 5);
    // R9: chain channel 2 from channel 1 (master, period 4)
    cfg(1, 1, 4, 1);
    cfg(2, 5, 3, 1);
    measure(2, c); check(c == 12, "R9", "chained spacing", c, 12);
    // R9: channel 0 with code 5 runs from 32 kHz
    cfg(0, 5, 2, 1);
    measure(0, c); check(c == 2 * K32, "R9", "head code5", c, 2 * K32);
    // R10: pin shows latch when deselected
    @(posedge clk); #1; pin_sel = 4'b0000; out_latch = 4'b1010;
    @(negedge clk); check(pin_out == 4'b1010, "R10", "latch pass", int'(pin_out), 10);
    @(posedge clk); #1; pin_sel = 4'b1111;
    @(negedge clk); check(pin_out == pwm_out, "R10", "pwm select", int'(pin_out), int'(pwm_out));
    repeat (50) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule